// File: doc/BRIEF.md
# Off-Chip Address Translation and Trap Unit

This block sits on the address path between a processor's fetch/load port and its memory system. Every request address is first compared against the top of on-chip memory. An address below that limit goes out unchanged in the same cycle. An address at or above the limit is looked up in a small fully associative translation buffer. On a hit, the buffer supplies a physical page number and a 2-bit target device code, and the translated access goes out in the same cycle with no software involved. The downstream cache sees only the translated address and is free to use any line size.

On a miss, the requester is stalled. One cycle later the unit posts a trap that carries the untranslated address to a software handler. The handler sleeps until a trap is posted. It accepts the trap, can refill a buffer entry through the refill port, and returns the data word. The requester is released in the cycle that word arrives. Only one trap is outstanding at a time.

The buffer depth is a parameter. A depth of zero removes the buffer, so every off-chip access traps, which gives fully deterministic timing.

Top module: `xlat_trap_unit`

## Requirements
- R1: A request with address below ONCHIP_BYTES (default 0x40000) gives, in the same cycle, mem_valid=1, mem_local=1, mem_dev=0, mem_addr equal to req_addr, and req_stall=0. Address 0x40000 is already off-chip.
- R2: An off-chip request whose page number (address bits 31:12) matches a valid entry gives, in the same cycle, mem_valid=1, mem_local=0, mem_addr = {entry physical page, req_addr[11:0]}, mem_dev = the entry's device code, and req_stall=0.
- R3: An off-chip request that matches no valid entry raises req_stall and keeps mem_valid=0 in the same cycle. trap_valid rises on the next clock with trap_addr equal to the untranslated request address. Both hold steady until trap_ready is seen high.
- R4: After the trap is accepted, req_stall stays high until resp_valid. In the cycle resp_valid is high, rdata_valid=1, rdata=resp_data and req_stall=0. A resp_valid pulse while no accepted trap is waiting is ignored, and rdata_valid stays 0.
- R5: Only one trap is outstanding at a time. From the miss until the response, no request produces mem_valid, including on-chip requests. trap_valid falls on the clock after it is accepted and stays low while the response is awaited.
- R6: Each refill write goes into the entry selected by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one per write, wrapping after ENTRIES-1. With 8 entries, the ninth write replaces the first one written.
- R7: One cycle of inv_all makes every entry invalid from the next cycle onward. If inv_all and refill_we are high in the same cycle, inv_all wins, the write is dropped and the pointer does not move.
- R8: With ENTRIES=0 the refill port has no effect, every off-chip request traps, and on-chip requests still pass through as in R1.
- R9: After reset all entries are invalid, trap_valid=0, req_stall=0 and rdata_valid=0.
- R10: A lookup made in the same cycle as a refill write sees the buffer contents from before that write. The new entry is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester presents an address |
| req_addr | input | ADDR_W | Requested (untranslated) address |
| req_stall | output | 1 | Requester must hold and wait |
| rdata_valid | output | 1 | Trap response word delivered to requester |
| rdata | output | DATA_W | Data word returned by the handler |
| mem_valid | output | 1 | Access issued downstream this cycle |
| mem_addr | output | ADDR_W | Downstream (translated or passed) address |
| mem_dev | output | 2 | Target device code, 0 for on-chip |
| mem_local | output | 1 | Access is to on-chip memory |
| trap_valid | output | 1 | Trap posted to the handler |
| trap_addr | output | ADDR_W | Faulting untranslated address |
| trap_ready | input | 1 | Handler accepts the trap |
| resp_valid | input | 1 | Handler returns the data word |
| resp_data | input | DATA_W | Returned data word |
| refill_we | input | 1 | Write one buffer entry |
| refill_vpn | input | ADDR_W-PAGE_BITS | Virtual page number to store |
| refill_ppn | input | ADDR_W-PAGE_BITS | Physical page number to store |
| refill_dev | input | 2 | Device code to store |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The pass-through, hit and miss-stall results are combinational and are due in the cycle of the request. The bench drives each request just after a falling edge and samples one time unit later, before the next rising edge. Single-cycle probes drop req_valid again before that edge, so a probed miss never starts a trap. trap_valid is due one rising edge after a held miss, and trap acceptance shows on the rising edge after trap_ready. A refill or invalidate takes effect on the rising edge that follows it, so the bench probes in the next low phase. rdata_valid follows resp_valid within the same cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int DEV_W = 2;
   typedef logic [DEV_W-1:0] dev_sel_t;
   localparam dev_sel_t DEV_ONCHIP = '0;

   typedef enum logic [1:0] {
      TS_IDLE = 2'd0,
      TS_POST = 2'd1,
      TS_WAIT = 2'd2
   } trap_state_e;
endpackage

// File: rtl/xlat_rr_ptr.sv
module xlat_rr_ptr #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (advance) begin
         ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             hit,
   output logic [VPN_W-1:0] hit_ppn,
   output dev_sel_t         hit_dev,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [VPN_W-1:0] wr_ppn,
   input  dev_sel_t         wr_dev,
   input  logic             inv_all
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   generate
      if (ENTRIES == 0) begin : g_none
         assign hit     = 1'b0;
         assign hit_ppn = '0;
         assign hit_dev = DEV_ONCHIP;
      end else begin : g_cam
         logic [ENTRIES-1:0] valid_q;
         logic [VPN_W-1:0]   vpn_q [ENTRIES];
         logic [VPN_W-1:0]   ppn_q [ENTRIES];
         dev_sel_t           dev_q [ENTRIES];
         logic [IDX_W-1:0]   victim;
         logic               do_write;

         assign do_write = wr_en & ~inv_all;

         xlat_rr_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_rr (
            .clk    (clk),
            .rst_n  (rst_n),
            .advance(do_write),
            .ptr    (victim)
         );

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_q <= '0;
            end else if (inv_all) begin
               valid_q <= '0;
            end else if (wr_en) begin
               valid_q[victim] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (do_write) begin
               vpn_q[victim] <= wr_vpn;
               ppn_q[victim] <= wr_ppn;
               dev_q[victim] <= wr_dev;
            end
         end

         // lowest matching index wins
         always_comb begin
            hit     = 1'b0;
            hit_ppn = '0;
            hit_dev = DEV_ONCHIP;
            for (int i = ENTRIES - 1; i >= 0; i--) begin
               if (valid_q[i] && (vpn_q[i] == lk_vpn)) begin
                  hit     = 1'b1;
                  hit_ppn = ppn_q[i];
                  hit_dev = dev_q[i];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/xlat_trap_fsm.sv
module xlat_trap_fsm
   import xlat_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss,
   input  logic [ADDR_W-1:0] miss_addr,
   input  logic              trap_ready,
   input  logic              resp_valid,
   output logic              trap_valid,
   output logic [ADDR_W-1:0] trap_addr,
   output logic              idle,
   output logic              resp_take
);
   trap_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         TS_IDLE: if (miss)       state_d = TS_POST;
         TS_POST: if (trap_ready) state_d = TS_WAIT;
         TS_WAIT: if (resp_valid) state_d = TS_IDLE;
         default:                 state_d = TS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= TS_IDLE;
         trap_addr <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == TS_IDLE && miss) trap_addr <= miss_addr;
      end
   end

   assign trap_valid = (state_q == TS_POST);
   assign idle       = (state_q == TS_IDLE);
   assign resp_take  = (state_q == TS_WAIT) && resp_valid;
endmodule

// File: rtl/xlat_trap_unit.sv
module xlat_trap_unit
   import xlat_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter int PAGE_BITS    = 12,
   parameter int ONCHIP_BYTES = 262144,
   parameter int ENTRIES      = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [ADDR_W-1:0]           req_addr,
   output logic                        req_stall,
   output logic                        rdata_valid,
   output logic [DATA_W-1:0]           rdata,
   output logic                        mem_valid,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic [1:0]                  mem_dev,
   output logic                        mem_local,
   output logic                        trap_valid,
   output logic [ADDR_W-1:0]           trap_addr,
   input  logic                        trap_ready,
   input  logic                        resp_valid,
   input  logic [DATA_W-1:0]           resp_data,
   input  logic                        refill_we,
   input  logic [ADDR_W-PAGE_BITS-1:0] refill_vpn,
   input  logic [ADDR_W-PAGE_BITS-1:0] refill_ppn,
   input  logic [1:0]                  refill_dev,
   input  logic                        inv_all
);
   localparam int VPN_W = ADDR_W - PAGE_BITS;
   localparam logic [ADDR_W:0] ONCHIP_LIM = (ADDR_W + 1)'(ONCHIP_BYTES);

   generate
      if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_W) begin : g_bad_page
         $error("xlat_trap_unit: PAGE_BITS must lie in 1..ADDR_W-1");
      end
      if (ONCHIP_BYTES < 0 || ENTRIES < 0) begin : g_bad_count
         $error("xlat_trap_unit: ONCHIP_BYTES and ENTRIES must be non-negative");
      end
      if (DEV_W != 2) begin : g_bad_dev
         $error("xlat_trap_unit: device code ports are 2 bits wide");
      end
   endgenerate

   logic             is_local;
   logic             tlb_hit;
   logic [VPN_W-1:0] hit_ppn;
   dev_sel_t         hit_dev;
   logic             fsm_idle;
   logic             miss;
   logic             resp_take;

   assign is_local = ({1'b0, req_addr} < ONCHIP_LIM);

   xlat_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_tlb (
      .clk    (clk),
      .rst_n  (rst_n),
      .lk_vpn (req_addr[ADDR_W-1:PAGE_BITS]),
      .hit    (tlb_hit),
      .hit_ppn(hit_ppn),
      .hit_dev(hit_dev),
      .wr_en  (refill_we),
      .wr_vpn (refill_vpn),
      .wr_ppn (refill_ppn),
      .wr_dev (refill_dev),
      .inv_all(inv_all)
   );

   assign miss      = req_valid & fsm_idle & ~is_local & ~tlb_hit;
   assign mem_valid = req_valid & fsm_idle & (is_local | tlb_hit);
   assign mem_local = is_local;
   assign mem_addr  = is_local ? req_addr : {hit_ppn, req_addr[PAGE_BITS-1:0]};
   assign mem_dev   = is_local ? DEV_ONCHIP : hit_dev;

   xlat_trap_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .miss      (miss),
      .miss_addr (req_addr),
      .trap_ready(trap_ready),
      .resp_valid(resp_valid),
      .trap_valid(trap_valid),
      .trap_addr (trap_addr),
      .idle      (fsm_idle),
      .resp_take (resp_take)
   );

   assign req_stall   = miss | (~fsm_idle & ~resp_take);
   assign rdata_valid = resp_take;
   assign rdata       = resp_data;
endmodule

// File: rtl/xlat_trap_unit_chk.sv
module xlat_trap_unit_chk #(
   parameter int ADDR_W       = 32,
   parameter int PAGE_BITS    = 12,
   parameter int ONCHIP_BYTES = 262144,
   parameter int ENTRIES      = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_stall,
   input logic              rdata_valid,
   input logic              mem_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [1:0]        mem_dev,
   input logic              mem_local,
   input logic              trap_valid,
   input logic [ADDR_W-1:0] trap_addr,
   input logic              trap_ready,
   input logic              resp_valid
);
   localparam logic [ADDR_W:0] LIM = (ADDR_W + 1)'(ONCHIP_BYTES);

   // R1
   onchip_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_local) |->
         (mem_addr == req_addr && mem_dev == 2'd0 && ({1'b0, req_addr} < LIM) && !req_stall));

   // R2
   offchip_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_local) |->
         (mem_addr[PAGE_BITS-1:0] == req_addr[PAGE_BITS-1:0] && ({1'b0, req_addr} >= LIM) && !req_stall));

   // R3
   trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && !trap_ready) |=> (trap_valid && $stable(trap_addr)));

   // R3
   trap_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> (req_stall && !mem_valid));

   // R4
   resp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_valid |-> (resp_valid && !req_stall && !trap_valid));

   // R5
   single_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_ready) |=> (!trap_valid && !mem_valid && (req_stall || rdata_valid || !req_valid)));

   generate
      if (ENTRIES == 0) begin : g_zero
         // R8
         zero_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mem_valid |-> mem_local);
      end
   endgenerate
endmodule

bind xlat_trap_unit xlat_trap_unit_chk #(
   .ADDR_W      (ADDR_W),
   .PAGE_BITS   (PAGE_BITS),
   .ONCHIP_BYTES(ONCHIP_BYTES),
   .ENTRIES     (ENTRIES)
) u_chk (.*);

// File: tb/xlat_trap_unit_test.sv
module xlat_trap_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        trap_ready = 1'b0;
   logic        resp_valid = 1'b0;
   logic [31:0] resp_data = '0;
   logic        refill_we = 1'b0;
   logic [19:0] refill_vpn = '0;
   logic [19:0] refill_ppn = '0;
   logic [1:0]  refill_dev = '0;
   logic        inv_all = 1'b0;

   logic        req_stall, rdata_valid, mem_valid, mem_local, trap_valid;
   logic [31:0] rdata, mem_addr, trap_addr;
   logic [1:0]  mem_dev;
   logic        z_req_stall, z_rdata_valid, z_mem_valid, z_mem_local, z_trap_valid;
   logic [31:0] z_rdata, z_mem_addr, z_trap_addr;
   logic [1:0]  z_mem_dev;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   xlat_trap_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_stall(req_stall), .rdata_valid(rdata_valid), .rdata(rdata),
      .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_dev(mem_dev), .mem_local(mem_local),
      .trap_valid(trap_valid), .trap_addr(trap_addr), .trap_ready(trap_ready),
      .resp_valid(resp_valid), .resp_data(resp_data), .refill_we(refill_we),
      .refill_vpn(refill_vpn), .refill_ppn(refill_ppn), .refill_dev(refill_dev),
      .inv_all(inv_all)
   );

   xlat_trap_unit #(.ENTRIES(0)) uut_zero (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_stall(z_req_stall), .rdata_valid(z_rdata_valid), .rdata(z_rdata),
      .mem_valid(z_mem_valid), .mem_addr(z_mem_addr), .mem_dev(z_mem_dev), .mem_local(z_mem_local),
      .trap_valid(z_trap_valid), .trap_addr(z_trap_addr), .trap_ready(trap_ready),
      .resp_valid(resp_valid), .resp_data(resp_data), .refill_we(refill_we),
      .refill_vpn(refill_vpn), .refill_ppn(refill_ppn), .refill_dev(refill_dev),
      .inv_all(inv_all)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic probe_start(input logic [31:0] a);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      #1;
   endtask

   task automatic probe_end();
      #1;
      req_valid = 1'b0;
   endtask

   task automatic refill(input logic [19:0] v, input logic [19:0] p, input logic [1:0] d);
      @(negedge clk);
      refill_we = 1'b1; refill_vpn = v; refill_ppn = p; refill_dev = d;
      @(negedge clk);
      refill_we = 1'b0;
   endtask

   task automatic expect_hit(input string req, input logic [31:0] a, input logic [31:0] exp_addr, input logic [1:0] exp_dev);
      probe_start(a);
      chk(req, "hit mem_valid", 32'(mem_valid), 32'd1);
      chk(req, "hit mem_addr", mem_addr, exp_addr);
      chk(req, "hit mem_dev", 32'(mem_dev), 32'(exp_dev));
      chk(req, "hit stall", 32'(req_stall), 32'd0);
      probe_end();
   endtask

   task automatic expect_miss(input string req, input logic [31:0] a);
      probe_start(a);
      chk(req, "miss stall", 32'(req_stall), 32'd1);
      chk(req, "miss mem_valid", 32'(mem_valid), 32'd0);
      probe_end();
   endtask

   // R9
   task automatic t_reset_state();
      do_reset();
      #1;
      chk("R9", "trap_valid", 32'(trap_valid), 32'd0);
      chk("R9", "req_stall", 32'(req_stall), 32'd0);
      chk("R9", "rdata_valid", 32'(rdata_valid), 32'd0);
      expect_miss("R9", 32'h8000_1234);
   endtask

   // R1, R8
   task automatic t_onchip();
      probe_start(32'h0001_2344);
      chk("R1", "mem_valid", 32'(mem_valid), 32'd1);
      chk("R1", "mem_addr", mem_addr, 32'h0001_2344);
      chk("R1", "mem_local", 32'(mem_local), 32'd1);
      chk("R1", "mem_dev", 32'(mem_dev), 32'd0);
      chk("R1", "stall", 32'(req_stall), 32'd0);
      chk("R8", "zero-depth on-chip pass", 32'(z_mem_valid), 32'd1);
      probe_end();
      probe_start(32'h0003_FFFC);
      chk("R1", "top on-chip word local", 32'(mem_local), 32'd1);
      probe_end();
      probe_start(32'h0004_0000);
      chk("R1", "limit is off-chip", 32'(mem_local), 32'd0);
      chk("R1", "limit empty buffer stalls", 32'(req_stall), 32'd1);
      probe_end();
   endtask

   // R3, R4, R5
   task automatic t_full_trap(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      #1;
      chk("R3", "stall on miss", 32'(req_stall), 32'd1);
      chk("R3", "no issue on miss", 32'(mem_valid), 32'd0);
      chk("R3", "trap not yet posted", 32'(trap_valid), 32'd0);
      @(negedge clk); #1;
      chk("R3", "trap_valid", 32'(trap_valid), 32'd1);
      chk("R3", "trap_addr", trap_addr, a);
      chk("R8", "zero-depth traps", 32'(z_trap_valid), 32'd1);
      @(negedge clk); #1;
      chk("R3", "trap held", 32'(trap_valid), 32'd1);
      chk("R3", "trap_addr held", trap_addr, a);
      resp_valid = 1'b1; resp_data = 32'hDEAD_0001;
      #1;
      chk("R4", "early resp ignored", 32'(rdata_valid), 32'd0);
      resp_valid = 1'b0;
      trap_ready = 1'b1;
      @(negedge clk);
      trap_ready = 1'b0;
      #1;
      chk("R5", "trap drops after accept", 32'(trap_valid), 32'd0);
      chk("R4", "still stalled", 32'(req_stall), 32'd1);
      req_addr = 32'h0000_0100;
      #1;
      chk("R5", "on-chip blocked while waiting", 32'(mem_valid), 32'd0);
      req_addr = a;
      @(negedge clk); #1;
      chk("R4", "stall holds without resp", 32'(req_stall), 32'd1);
      resp_valid = 1'b1; resp_data = d;
      #1;
      chk("R4", "rdata_valid", 32'(rdata_valid), 32'd1);
      chk("R4", "rdata", rdata, d);
      chk("R4", "stall released", 32'(req_stall), 32'd0);
      @(negedge clk);
      resp_valid = 1'b0; req_valid = 1'b0;
      #1;
      chk("R4", "rdata_valid drops", 32'(rdata_valid), 32'd0);
      chk("R5", "back to idle", 32'(trap_valid), 32'd0);
   endtask

   // R4
   task automatic t_stray_resp();
      @(negedge clk);
      resp_valid = 1'b1; resp_data = 32'h1234_5678;
      #1;
      chk("R4", "stray resp ignored", 32'(rdata_valid), 32'd0);
      @(negedge clk);
      resp_valid = 1'b0;
      expect_miss("R4", 32'h9000_0000);
   endtask

   // R2, R8
   task automatic t_hit();
      refill(20'h80001, 20'h00123, 2'd2);
      expect_hit("R2", 32'h8000_1ABC, 32'h0012_3ABC, 2'd2);
      probe_start(32'h8000_1ABC);
      chk("R2", "hit not local", 32'(mem_local), 32'd0);
      chk("R8", "zero-depth ignores refill", 32'(z_req_stall), 32'd1);
      chk("R8", "zero-depth no issue", 32'(z_mem_valid), 32'd0);
      probe_end();
      refill(20'hC0FFE, 20'h7F00F, 2'd1);
      expect_hit("R2", 32'hC0FF_E004, 32'h7F00_F004, 2'd1);
      expect_miss("R2", 32'h8000_2ABC);
   endtask

   // R10
   task automatic t_same_cycle();
      @(negedge clk);
      refill_we = 1'b1; refill_vpn = 20'hB0000; refill_ppn = 20'h00B0B; refill_dev = 2'd3;
      req_valid = 1'b1; req_addr = 32'hB000_0010;
      #1;
      chk("R10", "lookup sees old contents", 32'(req_stall), 32'd1);
      #1;
      req_valid = 1'b0;
      @(negedge clk);
      refill_we = 1'b0;
      expect_hit("R10", 32'hB000_0010, 32'h00B0_B010, 2'd3);
   endtask

   // R6
   task automatic t_round_robin();
      do_reset();
      for (int i = 0; i < 8; i++) refill(20'hA0000 + 20'(i), 20'h00100 + 20'(i), 2'(i));
      for (int i = 0; i < 8; i++)
         expect_hit("R6", 32'hA000_0000 + 32'(i << 12), 32'h0010_0000 + 32'(i << 12), 2'(i));
      refill(20'hA0008, 20'h001FF, 2'd0);
      expect_miss("R6", 32'hA000_0000);
      expect_hit("R6", 32'hA000_1000, 32'h0010_1000, 2'd1);
      expect_hit("R6", 32'hA000_8000, 32'h001F_F000, 2'd0);
   endtask

   // R7
   task automatic t_invalidate();
      @(negedge clk);
      inv_all = 1'b1;
      refill_we = 1'b1; refill_vpn = 20'hD0000; refill_ppn = 20'h00D00; refill_dev = 2'd1;
      @(negedge clk);
      inv_all = 1'b0; refill_we = 1'b0;
      expect_miss("R7", 32'hA000_1000);
      expect_miss("R7", 32'hA000_8000);
      expect_miss("R7", 32'hD000_0000);
      refill(20'hE0000, 20'h00E00, 2'd2);
      expect_hit("R7", 32'hE000_0040, 32'h00E0_0040, 2'd2);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual run still going, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      t_reset_state();
      t_onchip();
      t_full_trap(32'h8000_1234, 32'hCAFE_F00D);
      t_stray_resp();
      t_hit();
      t_same_cycle();
      t_full_trap(32'hF000_0FF8, 32'h0BAD_BEEF);
      t_round_robin();
      t_invalidate();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule